// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Detection

This block is a memory-mapped general-purpose I/O controller for a parameterised number of pins. The pin count must be a multiple of 32. Software reaches it through a plain 32-bit register bus: a byte address, a write strobe with write data, and combinational read data. Each control feature occupies one bank of 32-bit registers, and each register in a bank covers 32 pins. The bank for one feature is followed by the bank for the next.

Each pin has four controls:
- a synchronised level readback;
- a direction bit that drives the pad's output enable;
- an output value that changes only through separate write-one-to-set and write-one-to-clear registers;
- independent rising-edge and falling-edge detect enables.

A detected enabled edge latches a sticky status bit, which software clears by writing a one to it. A single interrupt line is high while any status bit is set.

Top module: `bank_gpio`

## Requirements
- R1: With NREG = PIN_COUNT/32, the register of feature f for bank k is at byte address f*NREG*4 + k*4. Pin p sits in bank p/32 at bit p%32. The feature indices are: level 0, direction 1, set 2, clear 3, rising-enable 4, falling-enable 5, edge-status 6.
- R2: The level register is read-only. It returns each pin's input after a two-flop synchroniser, so a pin change is readable from the second clock edge after it.
- R3: In the direction register a 1 makes a pin an output and a 0 makes it an input. The register value appears on `pinDir` on the clock edge after the write, and it reads back.
- R4: Writing a 1 to a bit of the set register drives that pin's output value high from the next edge. Bits written 0 are unchanged. No output changes without a set or clear write.
- R5: Writing a 1 to a bit of the clear register drives that pin's output value low. Bits written 0 are unchanged.
- R6: The set and clear registers always read 0.
- R7: A rising edge on a synchronised pin whose rising enable is 1 sets that pin's status bit. An edge on a pin with both enables at 0 sets nothing.
- R8: A falling edge with the falling enable at 1 sets the status bit. With only the falling enable set, a rising edge sets nothing. With both enables set, either edge sets the bit.
- R9: Writing a 1 to a status bit clears only that bit. Status bits stay set until they are cleared.
- R10: If an enabled edge is detected in the same cycle as a write that clears the same status bit, the bit stays set.
- R11: `irqOut` is high exactly while at least one status bit in any bank is set.
- R12: An access to an address beyond the last status register, or to an address whose two low bits are not zero, reads 0 and is ignored on write.
- R13: After reset all pins are inputs, and all output values, edge enables and status bits are 0, so `irqOut` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte address, ADDR_W = clog2(7*NREG*4) |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| pinIn | input | PIN_COUNT | Asynchronous pin input levels |
| pinOut | output | PIN_COUNT | Output values of the pins |
| pinDir | output | PIN_COUNT | Per-pin output enable (1 = output) |
| irqOut | output | 1 | Interrupt, high while any status bit is set |

## Verification
The assertions assume a bus that holds address and data stable for the whole cycle in which the write strobe is high. They also assume that the only registers capable of changing `pinOut` are the set and clear registers. The stimulus changes the bus and the pins only just after a rising edge, and issues single-cycle writes. Pin changes are spaced at least four cycles apart so that each edge passes through the synchroniser before the next one arrives. In the one deliberate collision, the status-clear write is placed in the exact cycle in which the synchronised edge is detected.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int FEAT_COUNT = 7;

  typedef enum logic [2:0] {
    FEAT_LEVEL = 3'd0,
    FEAT_DIR   = 3'd1,
    FEAT_SET   = 3'd2,
    FEAT_CLR   = 3'd3,
    FEAT_RISE  = 3'd4,
    FEAT_FALL  = 3'd5,
    FEAT_STAT  = 3'd6,
    FEAT_NONE  = 3'd7
  } feat_e;

  typedef struct packed {
    logic       wrDir;
    logic       wrSet;
    logic       wrClr;
    logic       wrRise;
    logic       wrFall;
    logic       wrAck;
    logic       rdHit;
    feat_e      rdFeat;
    logic [7:0] bank;
  } gpio_strobe_t;
endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NREG   = 2,
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output gpio_strobe_t      strobe
);
  int   wordIdx;
  int   featIdx;
  int   bankIdx;
  logic hit;

  always_comb begin
    wordIdx = int'(busAddr[ADDR_W-1:2]);
    hit     = (busAddr[1:0] == 2'b00) && (wordIdx < FEAT_COUNT * NREG);
    featIdx = wordIdx / NREG;
    bankIdx = wordIdx % NREG;
    strobe        = '0;
    strobe.rdHit  = hit;
    strobe.rdFeat = hit ? feat_e'(3'(featIdx)) : FEAT_NONE;
    strobe.bank   = 8'(bankIdx);
    strobe.wrDir  = busWrEn && hit && (featIdx == int'(FEAT_DIR));
    strobe.wrSet  = busWrEn && hit && (featIdx == int'(FEAT_SET));
    strobe.wrClr  = busWrEn && hit && (featIdx == int'(FEAT_CLR));
    strobe.wrRise = busWrEn && hit && (featIdx == int'(FEAT_RISE));
    strobe.wrFall = busWrEn && hit && (featIdx == int'(FEAT_FALL));
    strobe.wrAck  = busWrEn && hit && (featIdx == int'(FEAT_STAT));
  end
endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
#(
  parameter int PIN_COUNT = 64,
  parameter int NREG      = PIN_COUNT / 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  gpio_strobe_t         strobe,
  input  logic [31:0]          busWdata,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinDir,
  output logic [31:0]          busRdata,
  output logic                 irqOut
);
  logic [PIN_COUNT-1:0] syncA, syncB, prevB;
  logic [PIN_COUNT-1:0] dirQ, outQ, riseQ, fallQ, statQ;
  logic [PIN_COUNT-1:0] edgeHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevB <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
      prevB <= syncB;
    end
  end

  assign edgeHit = (syncB & ~prevB & riseQ) | (~syncB & prevB & fallQ);

  for (genvar b = 0; b < NREG; b++) begin : g_bank
    logic        sel;
    logic [31:0] dirR, outR, riseR, fallR, statR, ackMask;
    assign sel     = (strobe.bank == 8'(b));
    assign ackMask = (strobe.wrAck && sel) ? busWdata : 32'd0;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        dirR  <= '0;
        outR  <= '0;
        riseR <= '0;
        fallR <= '0;
        statR <= '0;
      end else begin
        if (strobe.wrDir && sel)  dirR  <= busWdata;
        if (strobe.wrRise && sel) riseR <= busWdata;
        if (strobe.wrFall && sel) fallR <= busWdata;
        if (strobe.wrSet && sel)      outR <= outR | busWdata;
        else if (strobe.wrClr && sel) outR <= outR & ~busWdata;
        statR <= (statR & ~ackMask) | edgeHit[b*32 +: 32];
      end
    end

    assign dirQ[b*32 +: 32]  = dirR;
    assign outQ[b*32 +: 32]  = outR;
    assign riseQ[b*32 +: 32] = riseR;
    assign fallQ[b*32 +: 32] = fallR;
    assign statQ[b*32 +: 32] = statR;
  end

  int rdBank;
  always_comb begin
    rdBank   = strobe.rdHit ? int'(strobe.bank) : 0;
    busRdata = '0;
    case (strobe.rdFeat)
      FEAT_LEVEL: busRdata = syncB[rdBank*32 +: 32];
      FEAT_DIR:   busRdata = dirQ[rdBank*32 +: 32];
      FEAT_RISE:  busRdata = riseQ[rdBank*32 +: 32];
      FEAT_FALL:  busRdata = fallQ[rdBank*32 +: 32];
      FEAT_STAT:  busRdata = statQ[rdBank*32 +: 32];
      default:    busRdata = '0;
    endcase
  end

  assign pinOut = outQ;
  assign pinDir = dirQ;
  assign irqOut = |statQ;
endmodule

// File: rtl/bank_gpio.sv
module bank_gpio
  import gpio_bank_pkg::*;
#(
  parameter int PIN_COUNT = 64,
  localparam int NREG     = PIN_COUNT / 32,
  localparam int ADDR_W   = $clog2(FEAT_COUNT * NREG * 4)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinDir,
  output logic                 irqOut
);
  gpio_strobe_t strobe;

  gpio_bank_ctrl #(.NREG(NREG), .ADDR_W(ADDR_W)) u_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strobe  (strobe)
  );

  gpio_bank_dp #(.PIN_COUNT(PIN_COUNT), .NREG(NREG)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busWdata (busWdata),
    .pinIn    (pinIn),
    .pinOut   (pinOut),
    .pinDir   (pinDir),
    .busRdata (busRdata),
    .irqOut   (irqOut)
  );
endmodule

// File: rtl/bank_gpio_chk.sv
module bank_gpio_chk #(
  parameter int PIN_COUNT = 64,
  parameter int ADDR_W    = 6
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_W-1:0]    busAddr,
  input logic                 busWrEn,
  input logic [31:0]          busWdata,
  input logic [31:0]          busRdata,
  input logic [PIN_COUNT-1:0] pinOut,
  input logic [PIN_COUNT-1:0] pinDir,
  input logic                 irqOut
);
  localparam int NREG = PIN_COUNT / 32;
  int   word;
  logic aligned, inMap, setWr0, clrWr0, outWr, outRd, ackWr;

  always_comb begin
    word    = int'(busAddr[ADDR_W-1:2]);
    aligned = (busAddr[1:0] == 2'b00);
    inMap   = aligned && (word < 7 * NREG);
    setWr0  = busWrEn && aligned && (word == 2 * NREG);
    clrWr0  = busWrEn && aligned && (word == 3 * NREG);
    outRd   = aligned && (word >= 2 * NREG) && (word < 4 * NREG);
    outWr   = busWrEn && outRd;
    ackWr   = busWrEn && aligned && (word >= 6 * NREG) && (word < 7 * NREG);
  end

  // R4
  set_bank0_chk: assert property (@(posedge clk) disable iff (!rstN)
    setWr0 |=> ((pinOut[31:0] & $past(busWdata)) == $past(busWdata)));

  // R5
  clr_bank0_chk: assert property (@(posedge clk) disable iff (!rstN)
    clrWr0 |=> ((pinOut[31:0] & $past(busWdata)) == 32'd0));

  // R4
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outWr |=> $stable(pinOut));

  // R6
  setclr_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    outRd |-> (busRdata == 32'd0));

  // R9
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !ackWr) |=> irqOut);

  // R12
  oor_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && !inMap) |=> ($stable(pinDir) && $stable(pinOut)));

  // R12
  oor_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inMap |-> (busRdata == 32'd0));
endmodule

bind bank_gpio bank_gpio_chk #(.PIN_COUNT(PIN_COUNT), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWrEn  (busWrEn),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .pinOut   (pinOut),
  .pinDir   (pinDir),
  .irqOut   (irqOut)
);

// File: tb/bank_gpio_bench.sv
module bank_gpio_bench;
  localparam int PINS   = 64;
  localparam int NREG   = PINS / 32;
  localparam int ADDR_W = $clog2(7 * NREG * 4);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic              busWrEn = 1'b0;
  logic [31:0]       busWdata = '0;
  logic [31:0]       busRdata;
  logic [PINS-1:0]   pinIn = '0;
  logic [PINS-1:0]   pinOut;
  logic [PINS-1:0]   pinDir;
  logic              irqOut;

  always #2 clk = ~clk;

  bank_gpio #(.PIN_COUNT(PINS)) u_bank_gpio (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn),
    .pinOut(pinOut), .pinDir(pinDir), .irqOut(irqOut)
  );

  typedef struct {
    int          sel;
    logic [63:0] exp;
    string       tag;
  } item_t;

  item_t expQ[$];
  int    checks = 0;
  int    fails  = 0;
  int    cycles = 0;
  bit    doneFlag = 0;

  function automatic logic [ADDR_W-1:0] regAddr(int feat, int bank);
    return ADDR_W'(feat * NREG * 4 + bank * 4);
  endfunction

  task automatic writeReg(logic [ADDR_W-1:0] a, logic [31:0] d);
    @(posedge clk); #1;
    busAddr = a; busWdata = d; busWrEn = 1'b1;
    @(posedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic checkRd(logic [ADDR_W-1:0] a, logic [31:0] e, string tag);
    item_t it;
    @(posedge clk); #1;
    busAddr = a;
    it.sel = 0; it.exp = {32'd0, e}; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic checkPort(int sel, logic [63:0] e, string tag);
    item_t it;
    @(posedge clk); #1;
    it.sel = sel; it.exp = e; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Monitor: pops expectations and compares at the falling edge
  initial begin
    forever begin
      item_t it;
      logic [63:0] act;
      @(negedge clk);
      cycles++;
      if (cycles > 20000 && !doneFlag) begin
        fails++;
        $display("FAIL watchdog expired after %0d cycles", cycles);
        summary();
      end
      if (expQ.size() > 0) begin
        it = expQ.pop_front();
        case (it.sel)
          0:       act = {32'd0, busRdata};
          1:       act = pinOut;
          2:       act = pinDir;
          default: act = {63'd0, irqOut};
        endcase
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    idle(3);
    #1 rstN = 1'b1;

    // R13 reset state
    checkPort(2, 64'd0, "R13 pinDir after reset");
    checkPort(1, 64'd0, "R13 pinOut after reset");
    checkPort(3, 64'd0, "R13 irqOut after reset");
    checkRd(regAddr(6, 0), 32'd0, "R13 status bank0 after reset");
    checkRd(regAddr(4, 1), 32'd0, "R13 rise enable bank1 after reset");

    // R3 / R1 direction in bank 1
    writeReg(regAddr(1, 1), 32'hF0F0_0001);
    checkPort(2, {32'hF0F0_0001, 32'd0}, "R3 pinDir after write");
    checkRd(regAddr(1, 1), 32'hF0F0_0001, "R1 direction bank1 readback");
    checkRd(regAddr(1, 0), 32'd0, "R1 direction bank0 untouched");

    // R4 / R5 set and clear
    writeReg(regAddr(2, 0), 32'h0000_00A5);
    writeReg(regAddr(2, 1), 32'h8000_0000);
    checkPort(1, {32'h8000_0000, 32'h0000_00A5}, "R4 set bank0 and bank1");
    writeReg(regAddr(3, 0), 32'h0000_0005);
    checkPort(1, {32'h8000_0000, 32'h0000_00A0}, "R5 clear keeps other bits");

    // R6 set/clear read zero
    checkRd(regAddr(2, 0), 32'd0, "R6 set reads zero");
    checkRd(regAddr(3, 1), 32'd0, "R6 clear reads zero");

    // R2 level readback
    @(posedge clk); #1 pinIn = 64'hDEAD_BEEF_1234_5678;
    idle(3);
    checkRd(regAddr(0, 0), 32'h1234_5678, "R2 level bank0");
    checkRd(regAddr(0, 1), 32'hDEAD_BEEF, "R2 level bank1");
    checkPort(3, 64'd0, "R7 edges with enables off set nothing");

    // R7 rising edge on pin 0
    writeReg(regAddr(4, 0), 32'h0000_0005);   // rise on pins 0 and 2
    writeReg(regAddr(5, 0), 32'h0000_0004);   // fall on pin 2
    writeReg(regAddr(5, 1), 32'h0000_0100);   // fall on pin 40
    @(posedge clk); #1 pinIn[0] = 1'b1;
    idle(4);
    checkRd(regAddr(6, 0), 32'h0000_0001, "R7 rising edge latched");
    checkPort(3, 64'd1, "R11 irq from one status bit");

    // R8 falling-only pin 40
    @(posedge clk); #1 pinIn[40] = 1'b1;
    idle(4);
    checkRd(regAddr(6, 1), 32'd0, "R8 rising edge ignored on fall-only pin");
    @(posedge clk); #1 pinIn[40] = 1'b0;
    idle(4);
    checkRd(regAddr(6, 1), 32'h0000_0100, "R8 falling edge latched");

    // R8 both edges on pin 2
    @(posedge clk); #1 pinIn[2] = 1'b1;
    idle(4);
    checkRd(regAddr(6, 0), 32'h0000_0005, "R8 both-edge pin rising");
    writeReg(regAddr(6, 0), 32'h0000_0004);
    checkRd(regAddr(6, 0), 32'h0000_0001, "R9 clear only written bit");
    @(posedge clk); #1 pinIn[2] = 1'b0;
    idle(4);
    checkRd(regAddr(6, 0), 32'h0000_0005, "R8 both-edge pin falling");

    // R9 / R11 clear everything
    writeReg(regAddr(6, 0), 32'h0000_0001);
    checkRd(regAddr(6, 0), 32'h0000_0004, "R9 status after clearing bit0");
    checkPort(3, 64'd1, "R11 irq held by remaining bits");
    writeReg(regAddr(6, 0), 32'h0000_0004);
    writeReg(regAddr(6, 1), 32'h0000_0100);
    checkPort(3, 64'd0, "R11 irq low when all cleared");

    // R10 edge coinciding with clear
    @(posedge clk); #1 pinIn[0] = 1'b0;
    idle(4);
    checkRd(regAddr(6, 0), 32'd0, "R10 precondition status clear");
    @(posedge clk); #1 pinIn[0] = 1'b1;
    @(posedge clk);
    writeReg(regAddr(6, 0), 32'h0000_0001);
    checkRd(regAddr(6, 0), 32'h0000_0001, "R10 edge wins over clear");
    checkPort(3, 64'd1, "R10 irq stays high");

    // R12 out of range and misaligned
    writeReg(ADDR_W'(56), 32'hFFFF_FFFF);
    writeReg(regAddr(1, 0) + ADDR_W'(1), 32'hFFFF_FFFF);
    writeReg(regAddr(2, 0) + ADDR_W'(2), 32'hFFFF_FFFF);
    checkPort(2, {32'hF0F0_0001, 32'd0}, "R12 pinDir unchanged");
    checkPort(1, {32'h8000_0000, 32'h0000_00A0}, "R12 pinOut unchanged");
    checkRd(ADDR_W'(60), 32'd0, "R12 out-of-range read zero");
    checkRd(regAddr(1, 1) + ADDR_W'(1), 32'd0, "R12 misaligned read zero");

    while (expQ.size() > 0) @(negedge clk);
    @(negedge clk);
    doneFlag = 1;
    summary();
  end
endmodule